// File: doc/BRIEF.md
# Serial EEPROM Block Reader

This block is a two-wire bus master that copies a run of consecutive bytes out of a small serial EEPROM into the surrounding logic. A one-cycle `start_i` pulse latches an 11-bit starting address and an 8-bit byte count. The block then sends a device-select byte for a write, which sets the EEPROM's internal pointer. It sends the low address byte and issues a repeated START. It sends the same select byte with the read bit set and then clocks in the requested number of bytes. Each byte is presented on `rd_data_o` with a one-cycle `rd_valid_o` strobe. At the end the block issues STOP and pulses `done_o`. `count_o` then holds the number of bytes delivered and `err_o` tells whether the device failed to acknowledge.

The EEPROM has no separate high-address byte. The three top address bits travel inside the select byte, in bit positions 3..1. The bus master drives SCL as a push-pull output. It only pulls SDA low (`sda_oe_o`) and otherwise leaves it to the pull-up. Every bus step is a state of one sequencer, and every step holds its line levels for a settle time measured in units of `UNIT_CYC` system clocks. A rising SCL edge waits two units. A falling SCL edge or an SDA change waits one unit.

Sequencer states. The idle state is S_IDLE. START uses S_STA_HI (both lines high) and S_STA_LO (SDA low under high SCL). Byte output uses S_TX_CLKLO, S_TX_BIT and S_TX_CLKHI. The device acknowledge uses S_ACK_REL, S_ACK_CLKHI, S_ACK_POLL and S_ACK_CLKLO. Byte input uses S_RX_CLKHI and S_RX_CLKLO. The master acknowledge uses S_MAK_LO, S_MAK_HI, S_MAK_END and S_MAK_REL. STOP uses S_SP_LO, S_SP_HI and S_SP_REL. The transitions are listed below:
- S_IDLE→S_STA_HI on a start with a non-zero count.
- S_STA_HI→S_STA_LO→S_TX_CLKLO.
- S_TX_CLKLO→S_TX_BIT while bits remain, otherwise S_TX_CLKLO→S_ACK_REL.
- S_TX_BIT→S_TX_CLKHI→S_TX_CLKLO.
- S_ACK_REL→S_ACK_CLKHI→S_ACK_POLL.
- S_ACK_POLL→S_ACK_CLKLO when SDA reads low or the poll limit runs out.
- From S_ACK_CLKLO, by phase: to S_TX_CLKLO after the write select, to S_STA_HI after the address byte, to S_RX_CLKHI after the read select, and to S_SP_LO on failure.
- S_RX_CLKHI→S_RX_CLKLO.
- S_RX_CLKLO→S_RX_CLKHI mid-byte, →S_MAK_LO after a byte that is not the last, →S_SP_LO after the last byte.
- S_MAK_LO→S_MAK_HI→S_MAK_END→S_MAK_REL→S_RX_CLKHI.
- S_SP_LO→S_SP_HI→S_SP_REL→S_IDLE.

Top module: `eep_block_reader`

## Requirements
- R1: After reset and while idle, SCL is high, SDA is released (`sda_oe_o`=0), and `done_o`, `rd_valid_o`, `err_o` and `count_o` are all 0.
- R2: The select byte is 1010 in bits 7..4, address bits 10..8 in bits 3..1, and the R/W bit in bit 0. R/W is 0 for the first select (pointer set) and 1 for the select after the repeated START.
- R3: A transfer on the bus is START, write select, acknowledge, address bits 7..0, acknowledge, repeated START, read select, acknowledge, data bytes, STOP. That gives exactly two START conditions and one STOP.
- R4: Bytes are sent MSB first. The master changes SDA only while SCL is low, except for the SDA fall of a START and the SDA rise of a STOP.
- R5: Each received byte, assembled MSB first, appears on `rd_data_o` with a one-cycle `rd_valid_o`, in address order starting at the given address. `count_o` equals the number of bytes delivered and never exceeds the requested count.
- R6: The master pulls SDA low for one SCL pulse after every received byte except the last. After the last byte it gives no ninth clock and goes to STOP.
- R7: If SDA stays high for `POLL_LIMIT` consecutive samples during an acknowledge wait, the transfer aborts: STOP is issued, `err_o` rises together with `done_o`, and no data byte is delivered.
- R8: After SCL rises, both lines hold for at least 2·`UNIT_CYC` clocks. After SCL falls or the master changes SDA, both lines hold for at least `UNIT_CYC` clocks.
- R9: `done_o` is a one-cycle pulse after the STOP completes. `err_o` and `count_o` then keep their values until the next start.
- R10: A start with a count of 0 pulses `done_o` one cycle later with `count_o`=0 and `err_o`=0, and produces no SCL activity.
- R11: A `start_i` pulse while a transfer is in progress is ignored: the transfer finishes with the original address and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| addr_i | input | 11 | Starting EEPROM byte address |
| len_i | input | 8 | Number of bytes to read |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_o | output | 1 | SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data_o | output | 8 | Most recently received byte |
| rd_valid_o | output | 1 | One-cycle strobe for `rd_data_o` |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | Last transfer aborted on a missing acknowledge |
| count_o | output | 8 | Bytes delivered by the last transfer |

## Verification
The bench drives the block against a behavioural EEPROM that decodes START and STOP from the wire. The model logs each select byte, counts master acknowledges, and can refuse to acknowledge. One corner is a start address near the top of the space, where the high bits must appear in the select byte. A block that dropped or shifted them would send a wrong select, and its data would not match. Another corner is the single-byte read: a design that acknowledged the last byte would give an extra ninth clock, and the model would count a master acknowledge it should not see. The device that never acknowledges must cost the full poll window and end with STOP and an error flag. A design that hung, skipped the STOP or flagged the error early fails there. The bench also measures the hold time of every line change against the settle rule, checks that a zero count produces no clocks, and sends a second start mid-transfer that must not redirect the read.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_STA_HI,
        S_STA_LO,
        S_TX_CLKLO,
        S_TX_BIT,
        S_TX_CLKHI,
        S_ACK_REL,
        S_ACK_CLKHI,
        S_ACK_POLL,
        S_ACK_CLKLO,
        S_RX_CLKHI,
        S_RX_CLKLO,
        S_MAK_LO,
        S_MAK_HI,
        S_MAK_END,
        S_MAK_REL,
        S_SP_LO,
        S_SP_HI,
        S_SP_REL
    } rd_state_t;

    typedef enum logic [1:0] {
        PH_SELW,
        PH_ADDR,
        PH_SELR
    } rd_phase_t;

    localparam logic [3:0] SEL_PREFIX = 4'hA;

endpackage

// File: rtl/eep_settle_timer.sv
module eep_settle_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         busy_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep_ack_watch.sv
module eep_ack_watch #(
    parameter int LIMIT = 1000,
    parameter int W     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic tick_i,
    output logic expire_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            q <= '0;
        end else if (tick_i && q != W'(LIMIT - 1)) begin
            q <= q + W'(1);
        end
    end

    assign expire_o = tick_i && (q == W'(LIMIT - 1));
endmodule

// File: rtl/eep_block_reader.sv
module eep_block_reader
    import eep_rd_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int LEN_W      = 8,
    parameter int UNIT_CYC   = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              sda_i,
    output logic              scl_o,
    output logic              sda_oe_o,
    output logic [7:0]        rd_data_o,
    output logic              rd_valid_o,
    output logic              done_o,
    output logic              err_o,
    output logic [LEN_W-1:0]  count_o
);
    localparam int TMR_W  = $clog2(2 * UNIT_CYC + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);

    rd_state_t         state_q, nxt_state;
    rd_phase_t         phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q, cnt_q;
    logic [7:0]        tx_q, rx_q, data_q;
    logic [3:0]        bit_q;
    logic [1:0]        lines_q, nxt_lines;
    logic              fail_q, err_q, valid_q, done_q;
    logic              go, tmr_busy, tmr_load, poll_exp;
    logic [TMR_W-1:0]  tmr_val;
    logic [2:0]        page;

    assign page = 3'(addr_q[ADDR_W-1:8]);
    assign go   = !tmr_busy;

    // Line levels {scl, sda} held while in each state
    function automatic logic [1:0] lines_of(rd_state_t s, logic tx_bit, logic keep);
        unique case (s)
            S_STA_LO, S_MAK_HI, S_SP_HI:                       return 2'b10;
            S_TX_CLKLO:                                         return {1'b0, keep};
            S_TX_BIT:                                           return {1'b0, tx_bit};
            S_TX_CLKHI:                                         return {1'b1, tx_bit};
            S_ACK_REL, S_ACK_CLKLO, S_RX_CLKLO, S_MAK_REL:      return 2'b01;
            S_MAK_LO, S_MAK_END, S_SP_LO:                       return 2'b00;
            default:                                            return 2'b11;
        endcase
    endfunction

    function automatic logic [TMR_W-1:0] settle(logic [1:0] cur, logic [1:0] nl);
        logic [TMR_W-1:0] d;
        d = '0;
        if (!cur[1] && nl[1])      d = TMR_W'(2 * UNIT_CYC);
        else if (cur[1] && !nl[1]) d = TMR_W'(UNIT_CYC);
        if (cur[0] != nl[0] && d < TMR_W'(UNIT_CYC)) d = TMR_W'(UNIT_CYC);
        return d;
    endfunction

    eep_settle_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(tmr_load),
        .val_i (tmr_val),
        .busy_o(tmr_busy)
    );

    eep_ack_watch #(.LIMIT(POLL_LIMIT), .W(POLL_W)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (go && state_q == S_ACK_CLKHI),
        .tick_i  (state_q == S_ACK_POLL && sda_i),
        .expire_o(poll_exp)
    );

    // Next-state logic
    always_comb begin
        nxt_state = state_q;
        if (go) begin
            unique case (state_q)
                S_IDLE:      if (start_i && len_i != '0) nxt_state = S_STA_HI;
                S_STA_HI:    nxt_state = S_STA_LO;
                S_STA_LO:    nxt_state = S_TX_CLKLO;
                S_TX_CLKLO:  nxt_state = (bit_q == 4'd8) ? S_ACK_REL : S_TX_BIT;
                S_TX_BIT:    nxt_state = S_TX_CLKHI;
                S_TX_CLKHI:  nxt_state = S_TX_CLKLO;
                S_ACK_REL:   nxt_state = S_ACK_CLKHI;
                S_ACK_CLKHI: nxt_state = S_ACK_POLL;
                S_ACK_POLL:  if (!sda_i || poll_exp) nxt_state = S_ACK_CLKLO;
                S_ACK_CLKLO: begin
                    if (fail_q)                 nxt_state = S_SP_LO;
                    else if (phase_q == PH_SELW) nxt_state = S_TX_CLKLO;
                    else if (phase_q == PH_ADDR) nxt_state = S_STA_HI;
                    else                         nxt_state = S_RX_CLKHI;
                end
                S_RX_CLKHI:  nxt_state = S_RX_CLKLO;
                S_RX_CLKLO: begin
                    if (bit_q != 4'd8)       nxt_state = S_RX_CLKHI;
                    else if (cnt_q == len_q) nxt_state = S_SP_LO;
                    else                     nxt_state = S_MAK_LO;
                end
                S_MAK_LO:    nxt_state = S_MAK_HI;
                S_MAK_HI:    nxt_state = S_MAK_END;
                S_MAK_END:   nxt_state = S_MAK_REL;
                S_MAK_REL:   nxt_state = S_RX_CLKHI;
                S_SP_LO:     nxt_state = S_SP_HI;
                S_SP_HI:     nxt_state = S_SP_REL;
                S_SP_REL:    nxt_state = S_IDLE;
                default:     nxt_state = S_IDLE;
            endcase
        end
        nxt_lines = lines_of(nxt_state, tx_q[7], lines_q[0]);
        tmr_load  = go && (nxt_state != state_q);
        tmr_val   = settle(lines_q, nxt_lines);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= nxt_state;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines_q <= 2'b11;
            phase_q <= PH_SELW;
            addr_q  <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            data_q  <= '0;
            bit_q   <= '0;
            fail_q  <= 1'b0;
            err_q   <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            if (go) begin
                lines_q <= nxt_lines;
                unique case (state_q)
                    S_IDLE: if (start_i) begin
                        addr_q  <= addr_i;
                        len_q   <= len_i;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                        fail_q  <= 1'b0;
                        phase_q <= PH_SELW;
                        done_q  <= (len_i == '0);
                    end
                    S_STA_LO: begin
                        tx_q  <= {SEL_PREFIX, page, phase_q == PH_SELR};
                        bit_q <= '0;
                    end
                    S_TX_CLKHI: begin
                        tx_q  <= {tx_q[6:0], 1'b0};
                        bit_q <= bit_q + 4'd1;
                    end
                    S_ACK_POLL: if (sda_i && poll_exp) fail_q <= 1'b1;
                    S_ACK_CLKLO: if (!fail_q) begin
                        unique case (phase_q)
                            PH_SELW: begin
                                phase_q <= PH_ADDR;
                                tx_q    <= addr_q[7:0];
                                bit_q   <= '0;
                            end
                            PH_ADDR: phase_q <= PH_SELR;
                            default: bit_q   <= '0;
                        endcase
                    end
                    S_RX_CLKHI: begin
                        rx_q  <= {rx_q[6:0], sda_i};
                        bit_q <= bit_q + 4'd1;
                        if (bit_q == 4'd7) begin
                            data_q  <= {rx_q[6:0], sda_i};
                            valid_q <= 1'b1;
                            cnt_q   <= cnt_q + LEN_W'(1);
                        end
                    end
                    S_MAK_REL: bit_q <= '0;
                    S_SP_REL: begin
                        done_q <= 1'b1;
                        err_q  <= fail_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_o      = lines_q[1];
    assign sda_oe_o   = !lines_q[0];
    assign rd_data_o  = data_q;
    assign rd_valid_o = valid_q;
    assign done_o     = done_q;
    assign err_o      = err_q;
    assign count_o    = cnt_q;
endmodule

// File: rtl/eep_rd_checker.sv
module eep_rd_checker
    import eep_rd_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_o,
    input logic             sda_oe_o,
    input logic             rd_valid_o,
    input logic             done_o,
    input logic             err_o,
    input logic [LEN_W-1:0] count_o,
    input logic [LEN_W-1:0] len_q,
    input rd_state_t        state_q
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (scl_o && !sda_oe_o));

    p_sda_low_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o) && !$stable(sda_oe_o)) |->
            (state_q == S_STA_LO || state_q == S_SP_REL));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= len_q);

    p_valid_at_byte_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> (state_q == S_RX_CLKLO));

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    p_rise_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_o) |=> ($stable(scl_o) && $stable(sda_oe_o)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && state_q != S_IDLE) |=> !done_o);
endmodule

bind eep_block_reader eep_rd_checker #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_o     (scl_o),
    .sda_oe_o  (sda_oe_o),
    .rd_valid_o(rd_valid_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .count_o   (count_o),
    .len_q     (len_q),
    .state_q   (state_q)
);

// File: tb/tb_eep_block_reader.sv
`timescale 1ns/1ps
module tb_eep_block_reader;
    localparam int UNIT = 4;
    localparam int POLL = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] addr_i = '0;
    logic [7:0]  len_i = '0;
    logic        scl_o, sda_oe_o, rd_valid_o, done_o, err_o;
    logic [7:0]  rd_data_o, count_o;
    logic        sl_drive = 1'b0;
    logic        sda_w;

    assign sda_w = !(sda_oe_o || sl_drive);

    always #5 clk = ~clk;

    eep_block_reader #(.UNIT_CYC(UNIT), .POLL_LIMIT(POLL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .len_i(len_i), .sda_i(sda_w), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
        .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
        .err_o(err_o), .count_o(count_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [7:0] mem_at(logic [10:0] a);
        return (a[7:0] * 8'd37) ^ {a[10:8], 5'b10110};
    endfunction

    // ---------------- behavioural EEPROM ----------------
    localparam int SL_IDLE = 0, SL_RCV = 1, SL_ACKW = 2, SL_SEND = 3, SL_MACK = 4;
    int          sl_st = SL_IDLE;
    int          sl_bit = 0;
    int          sl_idx = 0;
    logic [7:0]  sl_sh = '0, sl_cur = '0;
    logic [10:0] sl_ptr = '0;
    logic        sl_rw = 1'b0, sl_is_sel = 1'b0, sl_gotack = 1'b0;
    logic        nack_mode = 1'b0;
    logic [7:0]  log_selw = '0, log_selr = '0, log_alo = '0;
    int          n_start = 0, n_stop = 0, n_mack = 0, n_sent = 0, n_sclr = 0;

    always @(negedge sda_w) if (scl_o === 1'b1) begin
        n_start++; sl_st = SL_RCV; sl_bit = 0; sl_idx = 0; sl_drive = 1'b0;
    end

    always @(posedge sda_w) if (scl_o === 1'b1) begin
        n_stop++; sl_st = SL_IDLE; sl_drive = 1'b0;
    end

    always @(posedge scl_o) begin
        n_sclr++;
        if (sl_st == SL_RCV) begin
            sl_sh = {sl_sh[6:0], sda_w}; sl_bit++;
        end else if (sl_st == SL_SEND) begin
            sl_bit++;
        end else if (sl_st == SL_MACK) begin
            sl_gotack = !sda_w;
        end
    end

    always @(negedge scl_o) begin
        if (sl_st == SL_RCV && sl_bit == 8) begin
            sl_is_sel = (sl_idx == 0);
            if (sl_is_sel) begin
                sl_rw = sl_sh[0];
                sl_ptr[10:8] = sl_sh[3:1];
                if (sl_rw) log_selr = sl_sh; else log_selw = sl_sh;
                sl_drive = (sl_sh[7:4] == 4'hA) && !nack_mode;
            end else begin
                sl_ptr[7:0] = sl_sh; log_alo = sl_sh; sl_drive = 1'b1;
            end
            sl_idx++; sl_st = SL_ACKW;
        end else if (sl_st == SL_ACKW) begin
            if (!sl_drive) begin
                sl_st = SL_IDLE;
            end else if (sl_is_sel && sl_rw) begin
                sl_cur = mem_at(sl_ptr); sl_bit = 0; sl_st = SL_SEND;
                sl_drive = !sl_cur[7];
            end else begin
                sl_drive = 1'b0; sl_bit = 0; sl_st = SL_RCV;
            end
        end else if (sl_st == SL_SEND) begin
            if (sl_bit == 8) begin
                sl_drive = 1'b0; sl_ptr = sl_ptr + 11'd1; n_sent++; sl_st = SL_MACK;
            end else begin
                sl_drive = !sl_cur[7 - sl_bit];
            end
        end else if (sl_st == SL_MACK) begin
            if (sl_gotack) begin
                n_mack++; sl_cur = mem_at(sl_ptr); sl_bit = 0; sl_st = SL_SEND;
                sl_drive = !sl_cur[7];
            end else begin
                sl_st = SL_IDLE;
            end
        end
    end

    // ---------------- settle-time monitor (R8) ----------------
    logic [1:0] prev_ln = 2'b10;
    int         hold = 100, req = 0, n_viol = 0;
    always @(negedge clk) if (rst_n) begin
        if ({scl_o, sda_oe_o} != prev_ln) begin
            if (hold < req) n_viol++;
            req  = (!prev_ln[1] && scl_o) ? 2 * UNIT : UNIT;
            hold = 0;
            prev_ln = {scl_o, sda_oe_o};
        end else begin
            hold++;
        end
    end

    // ---------------- capture ----------------
    logic [7:0] cap [0:15];
    int         n_cap = 0;
    always @(negedge clk) if (rd_valid_o) begin
        if (n_cap < 16) cap[n_cap] = rd_data_o;
        n_cap++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_start = 0; n_stop = 0; n_mack = 0; n_sent = 0; n_cap = 0;
        n_viol = 0; n_sclr = 0;
    endtask

    task automatic fire(input logic [10:0] a, input logic [7:0] l);
        @(negedge clk);
        start_i = 1'b1; addr_i = a; len_i = l;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 20000) begin
            @(negedge clk); cyc++;
        end
        chk(done_o == 1'b1, "R9 done pulse seen", done_o, 1);
        @(negedge clk);
        chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        chk(scl_o == 1'b1, "R1 scl idle high", scl_o, 1);
        chk(sda_oe_o == 1'b0, "R1 sda released", sda_oe_o, 0);
        chk({done_o, rd_valid_o, err_o} == 3'b000, "R1 flags low", {done_o, rd_valid_o, err_o}, 0);
        chk(count_o == 8'd0, "R1 count zero", count_o, 0);
    endtask

    task automatic test_read(input logic [10:0] a, input logic [7:0] l);
        int cyc;
        clear_logs();
        fire(a, l);
        wait_done(cyc);
        chk(log_selw == {4'hA, a[10:8], 1'b0}, "R2 write select", log_selw, {4'hA, a[10:8], 1'b0});
        chk(log_selr == {4'hA, a[10:8], 1'b1}, "R2 read select", log_selr, {4'hA, a[10:8], 1'b1});
        chk(log_alo == a[7:0], "R4 address byte msb first", log_alo, a[7:0]);
        chk(n_start == 2 && n_stop == 1, "R3 start/stop count", n_start * 16 + n_stop, 33);
        chk(n_cap == int'(l), "R5 bytes delivered", n_cap, l);
        for (int i = 0; i < int'(l) && i < 16; i++) begin
            logic [10:0] ea;
            ea = a + 11'(i);
            chk(cap[i] == mem_at(ea), "R5 data byte", cap[i], mem_at(ea));
        end
        chk(count_o == l, "R5 count", count_o, l);
        chk(err_o == 1'b0, "R9 no error", err_o, 0);
        chk(n_mack == int'(l) - 1, "R6 master acks", n_mack, int'(l) - 1);
        chk(n_sent == int'(l), "R6 no extra clock", n_sent, l);
        chk(n_viol == 0, "R8 settle holds", n_viol, 0);
        chk(scl_o == 1'b1 && sda_oe_o == 1'b0, "R1 bus idle after", {scl_o, sda_oe_o}, 2);
    endtask

    task automatic test_nack();
        int cyc;
        clear_logs();
        nack_mode = 1'b1;
        fire(11'h123, 8'd3);
        wait_done(cyc);
        nack_mode = 1'b0;
        chk(err_o == 1'b1, "R7 error flag", err_o, 1);
        chk(count_o == 8'd0 && n_cap == 0, "R7 no data", n_cap, 0);
        chk(n_stop == 1 && n_start == 1, "R7 stop after abort", n_start * 16 + n_stop, 17);
        chk(cyc >= POLL, "R7 full poll window", cyc, POLL);
        @(negedge clk);
        chk(err_o == 1'b1, "R9 error held", err_o, 1);
    endtask

    task automatic test_len0();
        int cyc;
        clear_logs();
        fire(11'h040, 8'd0);
        chk(done_o == 1'b1, "R10 immediate done", done_o, 1);
        wait_done(cyc);
        chk(count_o == 8'd0 && err_o == 1'b0, "R10 zero count", count_o, 0);
        chk(n_sclr == 0 && n_start == 0, "R10 no bus activity", n_sclr, 0);
    endtask

    task automatic test_busy_start();
        int cyc;
        clear_logs();
        fire(11'h2C7, 8'd2);
        repeat (60) @(negedge clk);
        fire(11'h055, 8'd5);
        wait_done(cyc);
        chk(count_o == 8'd2 && n_cap == 2, "R11 original count", n_cap, 2);
        chk(log_selw == {4'hA, 3'b010, 1'b0}, "R11 original address", log_selw, 8'hA4);
        chk(cap[0] == mem_at(11'h2C7), "R11 original data", cap[0], mem_at(11'h2C7));
        repeat (20) @(negedge clk);
        chk(n_start == 2 && done_o == 1'b0, "R11 no second transfer", n_start, 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_read(11'h000, 8'd1);
        test_read(11'h5A3, 8'd4);
        test_read(11'h7FE, 8'd3);
        test_nack();
        test_len0();
        test_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule